// File: doc/BRIEF.md
# Page Column Pointer and Sequencer

This block keeps the byte column used to walk a 528-byte page buffer. The buffer has a low half (columns 0 to 255), a high half (256 to 511) and a 16-byte spare area (512 to 527). A one-byte region command picks which part the next start column falls in. A column address byte then sets the offset inside that part. Each serial strobe moves the column forward by one. The buffer memory itself lives outside this block.

When the last column is passed, one of two things happens. If sequential row reading is on and the current page is not the final page of its 16-page block, the block raises a one-cycle next-page request and puts the column back at the start of the selected region. In every other case the column stops, an end-of-page flag rises and stays high, and the column does not wrap. A static spare-disable input moves the last column from 527 down to 511 and makes the spare-region command have no effect.

Top module: `colptr_seq`

## Requirements
- R1: During and after synchronous reset, `col_o` is 0, `eop_o` and `next_page_o` are low, and the low-half region is selected.
- R2: Command code 0x00 selects the low half and stays in force across `op_end`. An address strobe then loads `col_o` = `addr_byte`.
- R3: Command code 0x01 selects the high half. An address strobe then loads `col_o` = 256 + `addr_byte`. The selection is dropped at `op_end`, and later loads fall back to the low half.
- R4: Command code 0x50 selects the spare region. An address strobe then loads `col_o` = 512 + `addr_byte[3:0]`, and bits 7:4 are ignored. The selection stays in force across `op_end`.
- R5: While `spare_dis` is high, command code 0x50 is ignored and the previous region stays selected.
- R6: A step strobe below the last column raises `col_o` by exactly one on the next clock. With no strobe, `col_o` holds.
- R7: The last column is 527 when `spare_dis` is low and 511 when it is high. A step at the last column with `seq_en` low sets `eop_o` and keeps `col_o` there. Further steps change nothing, and an address load clears `eop_o`.
- R8: With `seq_en` high and `page_idx` below 15, a step at the last column pulses `next_page_o` for exactly one cycle, sets `col_o` to the base of the current region (0, 256 or 512), and leaves `eop_o` low.
- R9: With `seq_en` high and `page_idx` equal to 15 (last page of the block), a step at the last column gives no next-page request and sets `eop_o` as in R7.
- R10: Command codes other than 0x00, 0x01 and 0x50 leave the region unchanged.
- R11: Stepping from the low or high half crosses into the next part without a break: 255 is followed by 256, and 511 is followed by 512 when `spare_dis` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Region command strobe |
| cmd_code | input | 8 | Region command code |
| addr_stb | input | 1 | Column address byte strobe |
| addr_byte | input | 8 | Column address byte |
| step_stb | input | 1 | Serial read/write strobe, advances column |
| spare_dis | input | 1 | Static: high excludes the spare area |
| op_end | input | 1 | End of current operation, clears high-half selection |
| seq_en | input | 1 | Sequential row reading enabled |
| page_idx | input | 4 | Page index within the current block |
| col_o | output | 10 | Current column |
| eop_o | output | 1 | End of page reached and held |
| next_page_o | output | 1 | One-cycle request to load the next page |

## Verification
Loads are tried with each region command and with bytes whose upper nibble is set. This shows whether the spare offset masks bits 7:4 and whether each region's base is added correctly. Sequences that place `op_end` between a command and a later load separate the one-shot high-half selection from the lasting low and spare selections. Unknown codes, and the spare code sent while `spare_dis` is high, show that the region does not move. Steps at 255, 511 and 527 under each setting of `spare_dis`, `seq_en` and `page_idx` separate a plain crossing, saturation, a row advance that returns to the region base, and termination at the end of a block.

// File: rtl/colptr_pkg.sv
package colptr_pkg;
  typedef enum logic [1:0] {
    RGN_LOW   = 2'd0,
    RGN_HIGH  = 2'd1,
    RGN_SPARE = 2'd2
  } rgn_e;

  // command codes decoded by the region selector
  localparam logic [7:0] CODE_LOW   = 8'h00;
  localparam logic [7:0] CODE_HIGH  = 8'h01;
  localparam logic [7:0] CODE_SPARE = 8'h50;
endpackage

// File: rtl/colptr_region.sv
module colptr_region
  import colptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_stb,
  input  logic [7:0] cmd_code,
  input  logic       op_end,
  input  logic       spare_dis,
  output rgn_e       rgn_o
);
  rgn_e lasting_q;
  logic high_once_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lasting_q   <= RGN_LOW;
      high_once_q <= 1'b0;
    end else begin
      if (cmd_stb) begin
        unique case (cmd_code)
          CODE_LOW: begin
            lasting_q   <= RGN_LOW;
            high_once_q <= 1'b0;
          end
          CODE_HIGH: high_once_q <= 1'b1;
          CODE_SPARE: begin
            if (!spare_dis) begin
              lasting_q   <= RGN_SPARE;
              high_once_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (op_end) begin
        high_once_q <= 1'b0;
      end
    end
  end

  assign rgn_o = high_once_q ? RGN_HIGH : lasting_q;
endmodule

// File: rtl/colptr_counter.sv
module colptr_counter
  import colptr_pkg::*;
#(
  parameter int MAIN_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int PAGES_PER_BLK = 16,
  parameter int BYTE_W        = 8,
  localparam int COL_W   = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int HALF    = MAIN_BYTES / 2,
  localparam int SPARE_W = $clog2(SPARE_BYTES),
  localparam int PG_W    = $clog2(PAGES_PER_BLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  rgn_e              rgn,
  input  logic              addr_stb,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              step_stb,
  input  logic              spare_dis,
  input  logic              seq_en,
  input  logic [PG_W-1:0]   page_idx,
  output logic [COL_W-1:0]  col_o,
  output logic              eop_o,
  output logic              next_page_o
);
  logic [COL_W-1:0] base_col, start_col, last_col;
  logic             can_advance;

  always_comb begin
    unique case (rgn)
      RGN_HIGH:  base_col = COL_W'(HALF);
      RGN_SPARE: base_col = COL_W'(MAIN_BYTES);
      default:   base_col = '0;
    endcase
    if (rgn == RGN_SPARE)
      start_col = base_col + COL_W'(addr_byte[SPARE_W-1:0]);
    else
      start_col = base_col + COL_W'(addr_byte);
    last_col    = spare_dis ? COL_W'(MAIN_BYTES - 1)
                            : COL_W'(MAIN_BYTES + SPARE_BYTES - 1);
    can_advance = seq_en && (page_idx != PG_W'(PAGES_PER_BLK - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o       <= '0;
      eop_o       <= 1'b0;
      next_page_o <= 1'b0;
    end else begin
      next_page_o <= 1'b0;
      if (addr_stb) begin
        col_o <= start_col;
        eop_o <= 1'b0;
      end else if (step_stb && !eop_o) begin
        if (col_o < last_col) begin
          col_o <= col_o + COL_W'(1);
        end else if (can_advance) begin
          col_o       <= base_col;
          next_page_o <= 1'b1;
        end else begin
          eop_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/colptr_seq.sv
module colptr_seq
  import colptr_pkg::*;
#(
  parameter int MAIN_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int PAGES_PER_BLK = 16,
  parameter int BYTE_W        = 8,
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int PG_W  = $clog2(PAGES_PER_BLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_code,
  input  logic              addr_stb,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              step_stb,
  input  logic              spare_dis,
  input  logic              op_end,
  input  logic              seq_en,
  input  logic [PG_W-1:0]   page_idx,
  output logic [COL_W-1:0]  col_o,
  output logic              eop_o,
  output logic              next_page_o
);
  rgn_e rgn;

  colptr_region u_region (
    .clk       (clk),
    .rst       (rst),
    .cmd_stb   (cmd_stb),
    .cmd_code  (cmd_code),
    .op_end    (op_end),
    .spare_dis (spare_dis),
    .rgn_o     (rgn)
  );

  colptr_counter #(
    .MAIN_BYTES    (MAIN_BYTES),
    .SPARE_BYTES   (SPARE_BYTES),
    .PAGES_PER_BLK (PAGES_PER_BLK),
    .BYTE_W        (BYTE_W)
  ) u_counter (
    .clk         (clk),
    .rst         (rst),
    .rgn         (rgn),
    .addr_stb    (addr_stb),
    .addr_byte   (addr_byte),
    .step_stb    (step_stb),
    .spare_dis   (spare_dis),
    .seq_en      (seq_en),
    .page_idx    (page_idx),
    .col_o       (col_o),
    .eop_o       (eop_o),
    .next_page_o (next_page_o)
  );
endmodule

// File: rtl/colptr_seq_chk.sv
module colptr_seq_chk #(
  parameter int MAIN_BYTES    = 512,
  parameter int SPARE_BYTES   = 16,
  parameter int PAGES_PER_BLK = 16,
  localparam int COL_W = $clog2(MAIN_BYTES + SPARE_BYTES),
  localparam int PG_W  = $clog2(PAGES_PER_BLK)
) (
  input logic             clk,
  input logic             rst,
  input logic             addr_stb,
  input logic             step_stb,
  input logic             spare_dis,
  input logic             seq_en,
  input logic [PG_W-1:0]  page_idx,
  input logic [COL_W-1:0] col_o,
  input logic             eop_o,
  input logic             next_page_o
);
  logic [COL_W-1:0] lim;
  always_comb lim = spare_dis ? COL_W'(MAIN_BYTES - 1)
                              : COL_W'(MAIN_BYTES + SPARE_BYTES - 1);

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (col_o == '0 && !eop_o && !next_page_o));

  // R6
  a_r6_step_adds_one: assert property (@(posedge clk) disable iff (rst)
    (step_stb && !addr_stb && !eop_o && col_o < lim)
      |=> col_o == $past(col_o) + COL_W'(1));

  // R6
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!addr_stb && !step_stb) |=> ($stable(col_o) && !next_page_o));

  // R7
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (eop_o && !addr_stb) |=> (eop_o && $stable(col_o)));

  // R8
  a_r8_pulse_without_eop: assert property (@(posedge clk) disable iff (rst)
    next_page_o |-> (!eop_o && !$past(next_page_o)));

  // R9
  a_r9_block_end: assert property (@(posedge clk) disable iff (rst)
    (step_stb && !addr_stb && seq_en && page_idx == PG_W'(PAGES_PER_BLK - 1))
      |=> !next_page_o);
endmodule

bind colptr_seq colptr_seq_chk #(
  .MAIN_BYTES    (MAIN_BYTES),
  .SPARE_BYTES   (SPARE_BYTES),
  .PAGES_PER_BLK (PAGES_PER_BLK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_stb    (addr_stb),
  .step_stb    (step_stb),
  .spare_dis   (spare_dis),
  .seq_en      (seq_en),
  .page_idx    (page_idx),
  .col_o       (col_o),
  .eop_o       (eop_o),
  .next_page_o (next_page_o)
);

// File: tb/colptr_seq_bench.sv
module colptr_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_stb = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       addr_stb = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic       step_stb = 1'b0;
  logic       spare_dis = 1'b0;
  logic       op_end = 1'b0;
  logic       seq_en = 1'b0;
  logic [3:0] page_idx = 4'd0;
  logic [9:0] col_o;
  logic       eop_o, next_page_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  colptr_seq u_colptr_seq (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .addr_stb(addr_stb), .addr_byte(addr_byte), .step_stb(step_stb),
    .spare_dis(spare_dis), .op_end(op_end), .seq_en(seq_en),
    .page_idx(page_idx), .col_o(col_o), .eop_o(eop_o),
    .next_page_o(next_page_o)
  );

  task automatic expect_out(string req, int col, bit eop, bit np);
    checks++;
    if (col_o !== 10'(col) || eop_o !== eop || next_page_o !== np) begin
      errors++;
      $display("FAIL %s: col=%0d eop=%0b np=%0b expected col=%0d eop=%0b np=%0b",
               req, col_o, eop_o, next_page_o, col, eop, np);
    end
  endtask

  task automatic send_cmd(logic [7:0] code);
    @(negedge clk); cmd_stb = 1'b1; cmd_code = code;
    @(negedge clk); cmd_stb = 1'b0;
  endtask

  task automatic send_addr(logic [7:0] b);
    @(negedge clk); addr_stb = 1'b1; addr_byte = b;
    @(negedge clk); addr_stb = 1'b0;
  endtask

  task automatic send_step();
    @(negedge clk); step_stb = 1'b1;
    @(negedge clk); step_stb = 1'b0;
  endtask

  task automatic send_end();
    @(negedge clk); op_end = 1'b1;
    @(negedge clk); op_end = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_out("R1 during reset", 0, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1 after reset", 0, 0, 0);
    send_addr(8'h21);
    expect_out("R1 default low region", 33, 0, 0);
  endtask

  task automatic t_low();
    send_cmd(8'h00); send_addr(8'h34);
    expect_out("R2 low load", 52, 0, 0);
    send_end(); send_addr(8'h10);
    expect_out("R2 persists", 16, 0, 0);
  endtask

  task automatic t_high();
    send_cmd(8'h01); send_addr(8'h05);
    expect_out("R3 high load", 261, 0, 0);
    send_end(); send_addr(8'h05);
    expect_out("R3 falls back to low", 5, 0, 0);
  endtask

  task automatic t_spare();
    send_cmd(8'h50); send_addr(8'hF3);
    expect_out("R4 spare load masks upper nibble", 515, 0, 0);
    send_end(); send_addr(8'h02);
    expect_out("R4 persists", 514, 0, 0);
    send_cmd(8'h90); send_addr(8'h07);
    expect_out("R10 unknown code ignored", 519, 0, 0);
    send_cmd(8'h00);
  endtask

  task automatic t_spare_disabled();
    spare_dis = 1'b1;
    send_cmd(8'h50); send_addr(8'h07);
    expect_out("R5 spare code ignored", 7, 0, 0);
    spare_dis = 1'b0;
  endtask

  task automatic t_step();
    send_addr(8'h10); send_step();
    expect_out("R6 step by one", 17, 0, 0);
    @(negedge clk);
    expect_out("R6 hold when idle", 17, 0, 0);
  endtask

  task automatic t_cross();
    send_addr(8'hFF); send_step();
    expect_out("R11 255 to 256", 256, 0, 0);
    send_cmd(8'h01); send_addr(8'hFF); send_step();
    expect_out("R11 511 to 512", 512, 0, 0);
    send_end(); send_cmd(8'h00);
  endtask

  task automatic t_saturate();
    send_cmd(8'h50); send_addr(8'h0F);
    expect_out("R7 at 527", 527, 0, 0);
    send_step();
    expect_out("R7 end flag", 527, 1, 0);
    send_step();
    expect_out("R7 no wrap", 527, 1, 0);
    send_addr(8'h00);
    expect_out("R7 load clears flag", 512, 0, 0);
    spare_dis = 1'b1;
    send_cmd(8'h00); send_cmd(8'h01); send_addr(8'hFF);
    send_step();
    expect_out("R7 last column 511", 511, 1, 0);
    send_end();
    spare_dis = 1'b0;
  endtask

  task automatic t_row_advance();
    seq_en = 1'b1; page_idx = 4'd3;
    send_cmd(8'h50); send_addr(8'h0E); send_step();
    expect_out("R8 before last", 527, 0, 0);
    send_step();
    expect_out("R8 spare advance", 512, 0, 1);
    @(negedge clk);
    expect_out("R8 single pulse", 512, 0, 0);
    spare_dis = 1'b1;
    send_cmd(8'h00); send_cmd(8'h01); send_addr(8'hFE); send_step();
    send_step();
    expect_out("R8 high advance to 256", 256, 0, 1);
    send_end();
    spare_dis = 1'b0;
  endtask

  task automatic t_block_end();
    page_idx = 4'd15;
    send_cmd(8'h50); send_addr(8'h0F); send_step();
    expect_out("R9 block end terminates", 527, 1, 0);
    seq_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: bench hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_low();
    t_high();
    t_spare();
    t_spare_disabled();
    t_step();
    t_cross();
    t_saturate();
    t_row_advance();
    t_block_end();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule